// File: doc/BRIEF.md
# Store-to-Load Forwarding Buffer

This block remembers stores that have been queued towards memory but not yet written. For each such address it holds the value of the newest pending store and the cycle in which that store was issued. A later load to the same address can then take its value from the buffer instead of waiting for a memory access. When memory reports that a write has finished, a retire request removes the matching entry.

Storage is a direct-mapped table. A slot is chosen by a few word-address bits, and the full address is kept as a tag. A second store to an address already held replaces the older one, which is flagged as redundant. A store whose slot holds a different address is refused and flagged as a conflict, so the caller keeps that store on its own path to memory.

Stores arrive on a valid/ready port. Back-pressure has one source: `st_ready` drops in any cycle where a retire is presented, because a retire takes the table's write path. A store moves only when `st_valid` and `st_ready` are both high. The load port has no stall. Every load request produces exactly one response on the next cycle.

Top module: `stfwd_buffer`

## Requirements
- R1: After reset every slot is empty. Loads miss, and `st_conflict` and `st_redundant` are low.
- R2: A store accepted into an empty slot is returned by a later load to the same address. The response has `ld_rsp_hit` high, the stored value and its issue cycle. `ld_rsp_valid` is high exactly in the cycle after each cycle with `ld_valid` high.
- R3: An accepted store to an address already held replaces its value and issue cycle. `st_redundant` pulses for one cycle after the store's handshake.
- R4: An accepted store whose slot holds a different address is not entered and the slot keeps its old contents. `st_conflict` pulses for one cycle after the store's handshake.
- R5: A retire whose address and issue cycle both match the held entry clears that slot. Later loads to that address miss.
- R6: A retire whose address or issue cycle does not match the held entry has no effect. The entry is still returned by a later load.
- R7: A load that misses returns `ld_rsp_hit` low, with `ld_rsp_data` and `ld_rsp_cyc` zero.
- R8: `st_ready` is low in every cycle where `rt_valid` is high. A store offered in such a cycle is not taken.
- R9: A load presented in the same cycle as a store sees the table as it was before that store.
- R10: The slot index is taken from address bits [OFS+IDX_W-1:OFS], which are bits 6:2 by default. Entries match only when the full address is equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | DATA_W | Store value |
| st_cyc | input | CYC_W | Store issue cycle |
| st_conflict | output | 1 | Previous store was refused because its slot is held by another address |
| st_redundant | output | 1 | Previous store replaced an older pending store |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | ADDR_W | Load byte address |
| ld_rsp_valid | output | 1 | Load response valid |
| ld_rsp_hit | output | 1 | Load address held in the buffer |
| ld_rsp_data | output | DATA_W | Forwarded value, zero on miss |
| ld_rsp_cyc | output | CYC_W | Issue cycle of the forwarded store, zero on miss |
| rt_valid | input | 1 | Retire request |
| rt_addr | input | ADDR_W | Retired store address |
| rt_cyc | input | CYC_W | Retired store issue cycle |

## Verification
The assertions assume that `rst_n` is held for at least one clock edge and that all inputs are stable around the rising edge. They also assume the caller never keeps a retire high long enough to starve a store that must eventually leave. The bench drives every input at the falling edge, so each is stable at the rising edge. It draws addresses from a small set of tags and slots so that hits, replacements and conflicts all occur often. Retires are drawn both from live entries and from stale issue cycles. The bench holds no assumption for longer than the current cycle, so a random retire may stall a store for a single cycle only.

// File: rtl/stfwd_pkg.sv
package stfwd_pkg;
  typedef enum logic [1:0] {
    ST_NONE     = 2'd0,
    ST_NEW      = 2'd1,
    ST_REPLACE  = 2'd2,
    ST_CONFLICT = 2'd3
  } st_outcome_e;
endpackage

// File: rtl/stfwd_table.sv
module stfwd_table
  import stfwd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CYC_W  = 16,
  parameter int DEPTH  = 32,
  parameter int OFS    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_fire,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [CYC_W-1:0]  st_cyc,
  input  logic              rt_valid,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic [CYC_W-1:0]  rt_cyc,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data,
  output logic [CYC_W-1:0]  rd_cyc,
  output st_outcome_e       st_outcome
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0]  vld_q;
  logic [ADDR_W-1:0] tag_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [CYC_W-1:0]  cyc_q  [DEPTH];

  logic [IDX_W-1:0] st_idx, rt_idx, rd_idx;
  assign st_idx = st_addr[OFS+IDX_W-1:OFS];
  assign rt_idx = rt_addr[OFS+IDX_W-1:OFS];
  assign rd_idx = rd_addr[OFS+IDX_W-1:OFS];

  logic st_same, st_busy, st_write, rt_match;
  assign st_same  = vld_q[st_idx] && (tag_q[st_idx] == st_addr);
  assign st_busy  = vld_q[st_idx] && (tag_q[st_idx] != st_addr);
  assign st_write = st_fire && !st_busy;
  assign rt_match = rt_valid && vld_q[rt_idx] && (tag_q[rt_idx] == rt_addr)
                    && (cyc_q[rt_idx] == rt_cyc);

  st_outcome_e outcome_d;
  always_comb begin
    outcome_d = ST_NONE;
    if (st_fire) begin
      if (st_busy)      outcome_d = ST_CONFLICT;
      else if (st_same) outcome_d = ST_REPLACE;
      else              outcome_d = ST_NEW;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q      <= '0;
      st_outcome <= ST_NONE;
    end else begin
      st_outcome <= outcome_d;
      if (rt_match)      vld_q[rt_idx] <= 1'b0;
      else if (st_write) vld_q[st_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st_write && !rt_valid) begin
      tag_q[st_idx]  <= st_addr;
      data_q[st_idx] <= st_data;
      cyc_q[st_idx]  <= st_cyc;
    end
  end

  assign rd_hit  = vld_q[rd_idx] && (tag_q[rd_idx] == rd_addr);
  assign rd_data = data_q[rd_idx];
  assign rd_cyc  = cyc_q[rd_idx];

  p_outcome_needs_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_outcome != ST_NONE) |-> $past(st_fire));
  p_conflict_keeps_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fire && st_busy && !rt_valid) |=> (tag_q[$past(st_idx)] == $past(tag_q[st_idx])));
  p_retire_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rt_match |=> !vld_q[$past(rt_idx)]);
  p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_write && !rt_valid) |=> vld_q[$past(st_idx)]);
endmodule

// File: rtl/stfwd_lookup.sv
module stfwd_lookup #(
  parameter int DATA_W = 32,
  parameter int CYC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CYC_W-1:0]  rd_cyc,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic [CYC_W-1:0]  rsp_cyc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
      rsp_cyc   <= '0;
    end else begin
      rsp_valid <= ld_valid;
      rsp_hit   <= ld_valid && rd_hit;
      rsp_data  <= (ld_valid && rd_hit) ? rd_data : '0;
      rsp_cyc   <= (ld_valid && rd_hit) ? rd_cyc  : '0;
    end
  end

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> rsp_valid);
  p_no_stray_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !rsp_valid);
  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_data == '0 && rsp_cyc == '0));
  p_hit_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
endmodule

// File: rtl/stfwd_buffer.sv
module stfwd_buffer
  import stfwd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CYC_W  = 16,
  parameter int DEPTH  = 32,
  parameter int OFS    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [CYC_W-1:0]  st_cyc,
  output logic              st_conflict,
  output logic              st_redundant,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_rsp_valid,
  output logic              ld_rsp_hit,
  output logic [DATA_W-1:0] ld_rsp_data,
  output logic [CYC_W-1:0]  ld_rsp_cyc,
  input  logic              rt_valid,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic [CYC_W-1:0]  rt_cyc
);
  logic              st_fire;
  logic              rd_hit;
  logic [DATA_W-1:0] rd_data;
  logic [CYC_W-1:0]  rd_cyc;
  st_outcome_e       outcome;

  assign st_ready = !rt_valid;
  assign st_fire  = st_valid && st_ready;

  stfwd_table #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC_W(CYC_W), .DEPTH(DEPTH), .OFS(OFS)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .st_fire(st_fire), .st_addr(st_addr), .st_data(st_data), .st_cyc(st_cyc),
    .rt_valid(rt_valid), .rt_addr(rt_addr), .rt_cyc(rt_cyc),
    .rd_addr(ld_addr), .rd_hit(rd_hit), .rd_data(rd_data), .rd_cyc(rd_cyc),
    .st_outcome(outcome)
  );

  stfwd_lookup #(.DATA_W(DATA_W), .CYC_W(CYC_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid),
    .rd_hit(rd_hit), .rd_data(rd_data), .rd_cyc(rd_cyc),
    .rsp_valid(ld_rsp_valid), .rsp_hit(ld_rsp_hit),
    .rsp_data(ld_rsp_data), .rsp_cyc(ld_rsp_cyc)
  );

  assign st_conflict  = (outcome == ST_CONFLICT);
  assign st_redundant = (outcome == ST_REPLACE);

  p_retire_blocks_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && rt_valid) |=> (!st_conflict && !st_redundant));
endmodule

// File: tb/stfwd_buffer_tb.sv
`timescale 1ns/1ps
module stfwd_buffer_tb;
  localparam int AW = 32, DW = 32, CW = 16, DEPTH = 32, OFS = 2;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 0, ld_valid = 0, rt_valid = 0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0, rt_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [CW-1:0] st_cyc = '0, rt_cyc = '0;
  logic st_ready, st_conflict, st_redundant;
  logic ld_rsp_valid, ld_rsp_hit;
  logic [DW-1:0] ld_rsp_data;
  logic [CW-1:0] ld_rsp_cyc;

  always #2.5 clk = ~clk;

  stfwd_buffer #(.ADDR_W(AW), .DATA_W(DW), .CYC_W(CW), .DEPTH(DEPTH), .OFS(OFS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .st_cyc(st_cyc), .st_conflict(st_conflict), .st_redundant(st_redundant),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_rsp_valid(ld_rsp_valid),
    .ld_rsp_hit(ld_rsp_hit), .ld_rsp_data(ld_rsp_data), .ld_rsp_cyc(ld_rsp_cyc),
    .rt_valid(rt_valid), .rt_addr(rt_addr), .rt_cyc(rt_cyc)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  bit          m_vld  [DEPTH];
  logic [AW-1:0] m_tag [DEPTH];
  logic [DW-1:0] m_data[DEPTH];
  logic [CW-1:0] m_cyc [DEPTH];

  function automatic int slot(input logic [AW-1:0] a);
    return int'(a[OFS+IW-1:OFS]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit ds, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                      input logic [CW-1:0] sc, input bit dl, input logic [AW-1:0] la,
                      input bit dr, input logic [AW-1:0] ra, input logic [CW-1:0] rc);
    bit fire, ehit, econf, ered;
    logic [DW-1:0] ed;
    logic [CW-1:0] ec;
    int si, li, ri;
    @(negedge clk);
    st_valid = ds; st_addr = sa; st_data = sd; st_cyc = sc;
    ld_valid = dl; ld_addr = la;
    rt_valid = dr; rt_addr = ra; rt_cyc = rc;
    #1;
    chk(st_ready == !dr, "R8 st_ready", st_ready, !dr);
    fire = ds && !dr;
    si = slot(sa); li = slot(la); ri = slot(ra);
    ehit = m_vld[li] && m_tag[li] == la;
    ed = ehit ? m_data[li] : '0;
    ec = ehit ? m_cyc[li] : '0;
    econf = fire && m_vld[si] && m_tag[si] != sa;
    ered  = fire && m_vld[si] && m_tag[si] == sa;
    @(posedge clk); #1;
    chk(ld_rsp_valid == dl, "R2 rsp_valid timing", ld_rsp_valid, dl);
    if (dl) begin
      chk(ld_rsp_hit == ehit, "R9/R10 hit", ld_rsp_hit, ehit);
      chk(ld_rsp_data == ed, ehit ? "R2 data" : "R7 miss data", ld_rsp_data, ed);
      chk(ld_rsp_cyc == ec, ehit ? "R3 cycle" : "R7 miss cycle", ld_rsp_cyc, ec);
    end
    chk(st_conflict == econf, "R4 conflict", st_conflict, econf);
    chk(st_redundant == ered, "R3 redundant", st_redundant, ered);
    if (dr && m_vld[ri] && m_tag[ri] == ra && m_cyc[ri] == rc) m_vld[ri] = 0;
    if (fire && !econf) begin
      m_vld[si] = 1; m_tag[si] = sa; m_data[si] = sd; m_cyc[si] = sc;
    end
  endtask

  task automatic idle();
    step(0, '0, '0, '0, 0, '0, 0, '0, '0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [CW-1:0] now;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    for (int i = 0; i < DEPTH; i++) begin
      m_vld[i] = 0; m_tag[i] = '0; m_data[i] = '0; m_cyc[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(st_conflict == 0 && st_redundant == 0 && ld_rsp_valid == 0, "R1 reset outputs",
        {st_conflict, st_redundant, ld_rsp_valid}, 0);
    @(negedge clk); rst_n = 1;
    // R1: empty after reset
    step(0, '0, '0, '0, 1, 32'h100, 0, '0, '0);
    // R9 + R2: same-cycle load misses, then hits
    step(1, 32'h100, 32'hAAAA, 16'd5, 1, 32'h100, 0, '0, '0);
    step(0, '0, '0, '0, 1, 32'h100, 0, '0, '0);
    // R3: replace
    step(1, 32'h100, 32'hBBBB, 16'd9, 0, '0, 0, '0, '0);
    step(0, '0, '0, '0, 1, 32'h100, 0, '0, '0);
    // R4 + R10: 0x180 shares slot 0 with 0x100
    step(1, 32'h180, 32'hCCCC, 16'd11, 0, '0, 0, '0, '0);
    step(0, '0, '0, '0, 1, 32'h100, 0, '0, '0);
    step(0, '0, '0, '0, 1, 32'h180, 0, '0, '0);
    // R6: stale cycle retire ignored
    step(0, '0, '0, '0, 0, '0, 1, 32'h100, 16'd5);
    step(0, '0, '0, '0, 1, 32'h100, 0, '0, '0);
    // R8 + R5: retire matching while store offered
    step(1, 32'h180, 32'hDDDD, 16'd12, 0, '0, 1, 32'h100, 16'd9);
    step(0, '0, '0, '0, 1, 32'h100, 0, '0, '0);
    step(0, '0, '0, '0, 1, 32'h180, 0, '0, '0);
    // R10: other slot
    step(1, 32'h184, 32'hEEEE, 16'd13, 1, 32'h184, 0, '0, '0);
    step(0, '0, '0, '0, 1, 32'h184, 0, '0, '0);
    step(0, '0, '0, '0, 1, 32'h104, 0, '0, '0);
    idle();

    now = 16'd100;
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] sa, la, ra;
      logic [CW-1:0] rc;
      bit ds, dl, dr;
      int pick;
      now++;
      sa = (AW'($urandom % 4) << 7) | (AW'($urandom % 4) << 2);
      la = (AW'($urandom % 4) << 7) | (AW'($urandom % 4) << 2);
      ds = ($urandom % 2) == 0;
      dl = ($urandom % 3) != 0;
      dr = ($urandom % 4) == 0;
      pick = $urandom % 4;
      if (m_vld[pick] && ($urandom % 3) != 0) begin
        ra = m_tag[pick];
        rc = ($urandom % 4 == 0) ? m_cyc[pick] - 1 : m_cyc[pick];
      end else begin
        ra = (AW'($urandom % 4) << 7) | (AW'($urandom % 4) << 2);
        rc = CW'($urandom % 200);
      end
      step(ds, sa, $urandom, now, dl, la, dr, ra, rc);
    end
    idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule